// File: doc/BRIEF.md
# Crossroads Lamp Sequencer with Seconds Display

This block drives the red, amber and green lamps of two crossing roads, called X and Y, from a single system clock. A divider turns the clock into a one-cycle pulse once per second. A four-phase state machine steps the two lamp sets on that pulse. The lamp phases are Y green, Y amber, X green and X amber. While Y shows green or amber, X shows red, and the reverse holds as well. Each red therefore lasts as long as the other road's green plus amber.

A two-digit seven-segment display shows how many seconds remain in the current phase. The count runs from the phase length down to 1. The two digits share one segment bus and are lit in turn at a scan rate set by a parameter. The one-second divider, the scan divider and the two phase lengths are all parameters. A small setup can therefore run the full sequence in a few hundred clocks.

Top module: `xing_light_ctrl`

## Requirements
- R1: While rst_ni is low, lamp_x_o and lamp_y_o are both 3'b000. Each lamp bus is ordered {red, amber, green}.
- R2: After reset the phases run in this fixed cycle:
  - Y green with X red (y=001, x=100).
  - Y amber with X red (y=010, x=100).
  - X green with Y red (x=001, y=100).
  - X amber with Y red (x=010, y=100).
  - Then back to Y green with X red.
- R3: Outside reset, each lamp bus has exactly one bit set, and at least one of the two buses shows red.
- R4: A green phase lasts GREEN_S*TICK_DIV clocks and an amber phase lasts AMBER_S*TICK_DIV clocks. Lamps change only on a clock edge that acts on a one-second pulse.
- R5: The first Y-green phase after reset release lasts exactly GREEN_S*TICK_DIV clocks, measured from the first edge after release.
- R6: The displayed value is the number of seconds remaining in the phase. It starts at the phase length on the phase's first edge and drops by one every TICK_DIV clocks, down to 1.
- R7: When dig_sel_no is 2'b10, the units digit is shown. seg_no carries {g,f,e,d,c,b,a} active low, so the digit 0 is 7'b1000000 and the digit 1 is 7'b1111001.
- R8: When dig_sel_no is 2'b01, the tens digit is shown. A tens value of zero is blanked, which means seg_no is 7'b1111111.
- R9: dig_sel_no is always 2'b10 or 2'b01 and toggles every SCAN_DIV clocks. Phase lengths must stay at or below 99 seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lamp_x_o | output | 3 | X road lamps {red, amber, green}, active high |
| lamp_y_o | output | 3 | Y road lamps {red, amber, green}, active high |
| seg_no | output | 7 | Segments {g..a}, active low |
| dig_sel_no | output | 2 | Digit select, active low: bit 1 tens, bit 0 units |

## Verification
Two events can fall on the same edge: the one-second pulse that ends a phase, and a flip of the scan multiplexer. On that edge the lamps, the reloaded countdown and the newly selected digit must all agree. The bench makes these coincide by choosing a tick period and a scan period that are coprime, so every alignment of the two occurs over a few cycles. Each sample is judged against arithmetic expectations. The expected phase comes from counting lamp changes, the expected remaining seconds from the clocks since the last change, and the expected segment pattern from that value and whichever digit is selected.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic [1:0] {
    PH_YG = 2'd0,
    PH_YA = 2'd1,
    PH_XG = 2'd2,
    PH_XA = 2'd3
  } phase_e;

  localparam logic [2:0] LAMP_RED = 3'b100;
  localparam logic [2:0] LAMP_AMB = 3'b010;
  localparam logic [2:0] LAMP_GRN = 3'b001;

  typedef struct packed {
    logic [2:0] x;
    logic [2:0] y;
  } lamps_t;

  function automatic lamps_t lamps_of(phase_e ph);
    lamps_t l;
    unique case (ph)
      PH_YG: begin l.x = LAMP_RED; l.y = LAMP_GRN; end
      PH_YA: begin l.x = LAMP_RED; l.y = LAMP_AMB; end
      PH_XG: begin l.x = LAMP_GRN; l.y = LAMP_RED; end
      default: begin l.x = LAMP_AMB; l.y = LAMP_RED; end
    endcase
    return l;
  endfunction

  // active-low {g,f,e,d,c,b,a}
  function automatic logic [6:0] seg_of(logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'd0: on = 7'b0111111;
      4'd1: on = 7'b0000110;
      4'd2: on = 7'b1011011;
      4'd3: on = 7'b1001111;
      4'd4: on = 7'b1100110;
      4'd5: on = 7'b1101101;
      4'd6: on = 7'b1111101;
      4'd7: on = 7'b0000111;
      4'd8: on = 7'b1111111;
      4'd9: on = 7'b1101111;
      default: on = 7'b1000000;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/xl_tick_div.sv
module xl_tick_div #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/xl_phase_fsm.sv
module xl_phase_fsm
  import xl_pkg::*;
#(
  parameter int unsigned GREEN_S = 30,
  parameter int unsigned AMBER_S = 5,
  parameter int unsigned RW      = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [RW-1:0] remain_o,
  output lamps_t        lamps_o
);
  phase_e        phase_q, phase_d;
  logic [RW-1:0] remain_d;

  function automatic logic [RW-1:0] reload_of(phase_e ph);
    return (ph == PH_YG || ph == PH_XG) ? RW'(GREEN_S) : RW'(AMBER_S);
  endfunction

  always_comb begin
    phase_d  = phase_q;
    remain_d = remain_o;
    if (tick_i) begin
      if (remain_o <= RW'(1)) begin
        phase_d  = phase_e'(phase_q + 2'd1);
        remain_d = reload_of(phase_d);
      end else begin
        remain_d = remain_o - 1'b1;
      end
    end
  end

  // lamps follow next phase so they switch on the same edge as the state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_YG;
      remain_o <= RW'(GREEN_S);
      lamps_o  <= '0;
    end else begin
      phase_q  <= phase_d;
      remain_o <= remain_d;
      lamps_o  <= lamps_of(phase_d);
    end
  end
endmodule

// File: rtl/xl_seg_scan.sv
module xl_seg_scan
  import xl_pkg::*;
#(
  parameter int unsigned SCAN_DIV = 25_000,
  parameter int unsigned RW       = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] remain_i,
  output logic [6:0]    seg_no,
  output logic [1:0]    dig_sel_no
);
  localparam int unsigned CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCAN_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tens_sel_q;
  logic [7:0]    val;
  logic [3:0]    tens, units;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      tens_sel_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q      <= '0;
      tens_sel_q <= ~tens_sel_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    val   = 8'(remain_i);
    tens  = 4'(val / 8'd10);
    units = 4'(val % 8'd10);
    if (tens_sel_q) begin
      dig_sel_no = 2'b01;
      seg_no     = (tens == 4'd0) ? 7'b1111111 : seg_of(tens);
    end else begin
      dig_sel_no = 2'b10;
      seg_no     = seg_of(units);
    end
  end
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
  import xl_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50_000_000,
  parameter int unsigned SCAN_DIV = 25_000,
  parameter int unsigned GREEN_S  = 30,
  parameter int unsigned AMBER_S  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] lamp_x_o,
  output logic [2:0] lamp_y_o,
  output logic [6:0] seg_no,
  output logic [1:0] dig_sel_no
);
  localparam int unsigned MAX_S = (GREEN_S > AMBER_S) ? GREEN_S : AMBER_S;
  localparam int unsigned RW    = $clog2(MAX_S + 1);

  logic          tick;
  logic [RW-1:0] remain;
  lamps_t        lamps;

  xl_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  xl_phase_fsm #(.GREEN_S(GREEN_S), .AMBER_S(AMBER_S), .RW(RW)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .remain_o(remain),
    .lamps_o (lamps)
  );

  xl_seg_scan #(.SCAN_DIV(SCAN_DIV), .RW(RW)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .remain_i  (remain),
    .seg_no    (seg_no),
    .dig_sel_no(dig_sel_no)
  );

  assign lamp_x_o = lamps.x;
  assign lamp_y_o = lamps.y;
endmodule

// File: rtl/xl_checker.sv
module xl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [2:0] lamp_x_i,
  input logic [2:0] lamp_y_i,
  input logic [1:0] dig_sel_ni
);
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  p_lamps_off_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (lamp_x_i == 3'b000 && lamp_y_i == 3'b000));

  p_one_lamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> ($onehot(lamp_x_i) && $onehot(lamp_y_i)));

  p_one_red_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (lamp_x_i[2] || lamp_y_i[2]));

  p_y_green_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && lamp_y_i == 3'b001) |=> (lamp_y_i inside {3'b001, 3'b010}));

  p_x_amber_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && lamp_x_i == 3'b010) |=> (lamp_x_i inside {3'b010, 3'b100}));

  p_hold_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !tick_i) |=> $stable({lamp_x_i, lamp_y_i}));

  p_digit_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(~dig_sel_ni));
endmodule

bind xing_light_ctrl xl_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .lamp_x_i  (lamp_x_o),
  .lamp_y_i  (lamp_y_o),
  .dig_sel_ni(dig_sel_no)
);

// File: tb/tb_xing_light_ctrl.sv
module tb_xing_light_ctrl;
  localparam int TD = 4;
  localparam int SD = 3;
  localparam int GS = 12;
  localparam int AS = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] lamp_x_o, lamp_y_o;
  logic [6:0] seg_no;
  logic [1:0] dig_sel_no;

  int n_chk = 0;
  int n_fail = 0;

  xing_light_ctrl #(.TICK_DIV(TD), .SCAN_DIV(SD), .GREEN_S(GS), .AMBER_S(AS)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lamp_x_o(lamp_x_o), .lamp_y_o(lamp_y_o),
    .seg_no(seg_no), .dig_sel_no(dig_sel_no)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] exp_seg(input int d);
    logic [6:0] lit;
    case (d)
      0: lit = 7'h3F; 1: lit = 7'h06; 2: lit = 7'h5B; 3: lit = 7'h4F;
      4: lit = 7'h66; 5: lit = 7'h6D; 6: lit = 7'h7D; 7: lit = 7'h07;
      8: lit = 7'h7F; default: lit = 7'h6F;
    endcase
    return ~lit;
  endfunction

  function automatic logic [5:0] exp_lamps(input int idx);
    case (idx)
      0: return {3'b100, 3'b001};
      1: return {3'b100, 3'b010};
      2: return {3'b001, 3'b100};
      default: return {3'b010, 3'b100};
    endcase
  endfunction

  function automatic int secs_of(input int idx);
    return (idx % 2 == 0) ? GS : AS;
  endfunction

  task automatic hold_reset(input int n);
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      chk({lamp_x_o, lamp_y_o} == 6'b0, "R1 lamps off in reset", {lamp_x_o, lamp_y_o}, 0);
    end
    rst_ni = 1'b1;
  endtask

  // runs after release; state of the model starts fresh
  task automatic run(input int n);
    int idx = 0;
    int k = 0;
    int rem;
    int run_len = 0;
    int toggles = 0;
    logic [5:0] prev;
    logic [1:0] prev_sel;
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      if (c == 0) begin
        chk({lamp_x_o, lamp_y_o} == exp_lamps(0), "R5 first phase Y green",
            {lamp_x_o, lamp_y_o}, exp_lamps(0));
      end else if ({lamp_x_o, lamp_y_o} != prev) begin
        chk(k + 1 == secs_of(idx) * TD, (idx == 0 && c < GS * TD + 2) ? "R5 first phase length" :
            "R4 phase length", k + 1, secs_of(idx) * TD);
        idx = (idx + 1) % 4;
        k = 0;
        chk({lamp_x_o, lamp_y_o} == exp_lamps(idx), "R2 phase order",
            {lamp_x_o, lamp_y_o}, exp_lamps(idx));
      end else begin
        k++;
      end
      prev = {lamp_x_o, lamp_y_o};
      chk($onehot(lamp_x_o) && $onehot(lamp_y_o) && (lamp_x_o[2] || lamp_y_o[2]),
          "R3 one lamp each, one red", {lamp_x_o, lamp_y_o}, exp_lamps(idx));
      rem = secs_of(idx) - k / TD;
      if (dig_sel_no == 2'b10)
        chk(seg_no == exp_seg(rem % 10), "R6 R7 units digit", seg_no, exp_seg(rem % 10));
      else if (dig_sel_no == 2'b01)
        chk(seg_no == ((rem / 10 == 0) ? 7'h7F : exp_seg(rem / 10)), "R6 R8 tens digit",
            seg_no, (rem / 10 == 0) ? 7'h7F : exp_seg(rem / 10));
      else
        chk(1'b0, "R9 digit select legal", dig_sel_no, 2'b10);
      if (c > 0 && dig_sel_no != prev_sel) begin
        if (toggles > 0) chk(run_len == SD, "R9 scan period", run_len, SD);
        toggles++;
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_sel = dig_sel_no;
    end
  endtask

  initial begin
    hold_reset(3);
    run(4 * 2 * (GS + AS) * TD + 7);
    hold_reset(2);
    run((GS + AS) * TD + 5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule